// File: doc/BRIEF.md
# Pipeline Stage Handshake Control

This block produces the load and discard strobes for every stage of an in-order pipeline (fetch, decode, execute, writeback in the default four-stage form) without a central stall unit. Each stage reports whether it holds a finished result (valid) and whether its own logic could take new work (local ready). The block combines these into a ready that travels from the writeback end toward fetch. From that ready it decides, stage by stage, whether the stage register loads the next instruction, drops what it holds, or keeps it.

A stage's decision uses only its own valid, its own flush request and the ready coming from the stage to its right. Nothing downstream ever looks at a stage further upstream. Flush requests come from a separate control-flow controller for branches, jumps and exceptions. They discard a stage's contents at once, whatever the ready chain says. The last stage has no neighbour to its right, so its downstream ready is permanently high. It waits only on its own local ready, for example while a load response is still outstanding. The block is purely combinational, so the strobes apply in the same cycle as the inputs.

Top module: `pipe_handshake_ctrl`

## Requirements
- R1: The propagated ready of stage i (bit i of `ready_o`, bit 0 = fetch, bit NUM_STAGES-1 = writeback) is high exactly when the stage's local ready is high and its downstream ready is high. The downstream ready of stage i is bit i+1 of `ready_o`, and is constant 1 for the writeback stage.
- R2: When a stage's downstream ready is high, its valid is high and its flush is low, its enable strobe is high and its clear strobe is low.
- R3: When a stage's downstream ready is high and its valid is low, its clear strobe is high and its enable strobe is low.
- R4: When a stage's downstream ready is low and its flush is low, both its enable and its clear strobes are low, so the stage holds its contents.
- R5: A high flush on a stage raises its clear strobe and forces its enable strobe low, whatever the valid and ready inputs are.
- R6: Enable and clear of one stage are never high together.
- R7: The ready, enable and clear of any stage do not depend on the valid, local ready or flush inputs of stages upstream of it.
- R8: The writeback stage enables whenever it is valid and not flushed, even when its own local ready is low; its local ready only gates the ready it passes upstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stage_valid_i | input | NUM_STAGES | Per-stage valid, bit 0 = fetch |
| local_ready_i | input | NUM_STAGES | Per-stage local ready |
| flush_i | input | NUM_STAGES | Per-stage flush request from the control-flow controller |
| stage_en_o | output | NUM_STAGES | Per-stage load strobe |
| stage_clr_o | output | NUM_STAGES | Per-stage discard strobe |
| ready_o | output | NUM_STAGES | Propagated ready of each stage |

## Verification
A flush and a normal advance can fall on the same stage in the same cycle: the stage is valid, the stages to its right are ready, and the control-flow controller asks to flush it. The bench provokes this by sweeping every combination of valid, local ready and flush over all stages, which includes the flush-on-advance cases. It also applies one directed pattern with flush on alternate stages of a fully ready, fully valid pipeline. Each time it judges that the clear wins, that the enable is suppressed, and that the ready passed upstream is unchanged by the flush.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Default pipeline depth: fetch, decode, execute, writeback
  localparam int unsigned HSK_DEF_STAGES = 4;

  // Control strobes driven into one stage register
  typedef struct packed {
    logic en;
    logic clr;
  } hsk_strobe_t;

endpackage

// File: rtl/hsk_ready_chain.sv
// Back-to-front ready propagation: each stage sees the ready of the stage
// to its right; the last stage sees a constant high.
module hsk_ready_chain #(
  parameter int unsigned NUM_STAGES = hsk_pkg::HSK_DEF_STAGES
) (
  input  logic [NUM_STAGES-1:0] local_ready_i,
  output logic [NUM_STAGES-1:0] down_ready_o,
  output logic [NUM_STAGES-1:0] prop_ready_o
);

  logic acc;

  always_comb begin
    acc          = 1'b1;
    down_ready_o = '0;
    prop_ready_o = '0;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      down_ready_o[i] = acc;
      acc             = acc & local_ready_i[i];
      prop_ready_o[i] = acc;
    end
  end

endmodule

// File: rtl/hsk_stage_ctrl.sv
// Strobe decision for a single stage.
module hsk_stage_ctrl
  import hsk_pkg::*;
(
  input  logic        valid_i,
  input  logic        down_ready_i,
  input  logic        flush_i,
  output hsk_strobe_t strobe_o
);

  always_comb begin
    strobe_o.en  = 1'b0;
    strobe_o.clr = 1'b0;
    if (flush_i) begin
      // control-flow flush wins over the handshake
      strobe_o.clr = 1'b1;
    end else if (down_ready_i) begin
      if (valid_i) strobe_o.en  = 1'b1;
      else         strobe_o.clr = 1'b1;
    end
  end

endmodule

// File: rtl/pipe_handshake_ctrl.sv
module pipe_handshake_ctrl
  import hsk_pkg::*;
#(
  parameter int unsigned NUM_STAGES = HSK_DEF_STAGES
) (
  input  logic [NUM_STAGES-1:0] stage_valid_i,
  input  logic [NUM_STAGES-1:0] local_ready_i,
  input  logic [NUM_STAGES-1:0] flush_i,
  output logic [NUM_STAGES-1:0] stage_en_o,
  output logic [NUM_STAGES-1:0] stage_clr_o,
  output logic [NUM_STAGES-1:0] ready_o
);

  localparam int unsigned LAST_STAGE = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] down_ready;
  logic [NUM_STAGES-1:0] prop_ready;
  hsk_strobe_t           strobe [NUM_STAGES];

  hsk_ready_chain #(
    .NUM_STAGES (NUM_STAGES)
  ) u_chain (
    .local_ready_i (local_ready_i),
    .down_ready_o  (down_ready),
    .prop_ready_o  (prop_ready)
  );

  for (genvar s = 0; s <= LAST_STAGE; s++) begin : g_stage
    hsk_stage_ctrl u_ctrl (
      .valid_i      (stage_valid_i[s]),
      .down_ready_i (down_ready[s]),
      .flush_i      (flush_i[s]),
      .strobe_o     (strobe[s])
    );
    assign stage_en_o[s]  = strobe[s].en;
    assign stage_clr_o[s] = strobe[s].clr;
  end

  assign ready_o = prop_ready;

endmodule

// File: rtl/pipe_handshake_chk.sv
// Port-level checks for pipe_handshake_ctrl; NUM_STAGES must be at least 2.
module pipe_handshake_chk #(
  parameter int unsigned NUM_STAGES = hsk_pkg::HSK_DEF_STAGES
) (
  input logic [NUM_STAGES-1:0] stage_valid_i,
  input logic [NUM_STAGES-1:0] local_ready_i,
  input logic [NUM_STAGES-1:0] flush_i,
  input logic [NUM_STAGES-1:0] stage_en_o,
  input logic [NUM_STAGES-1:0] stage_clr_o,
  input logic [NUM_STAGES-1:0] ready_o
);

  logic [NUM_STAGES-1:0] seen_down;

  always_comb seen_down = {1'b1, ready_o[NUM_STAGES-1:1]};

  always_comb begin
    for (int i = 0; i < NUM_STAGES; i++) begin
      assert_local_gates_ready_R1: assert (local_ready_i[i] || !ready_o[i]);
      assert_down_gates_ready_R1:  assert (seen_down[i] || !ready_o[i]);
      assert_advance_R2: assert (!(seen_down[i] && stage_valid_i[i] && !flush_i[i]) || stage_en_o[i]);
      assert_empty_clears_R3: assert (!(seen_down[i] && !stage_valid_i[i]) || stage_clr_o[i]);
      assert_hold_R4: assert (!(!seen_down[i] && !flush_i[i]) || (!stage_en_o[i] && !stage_clr_o[i]));
      assert_flush_clears_R5: assert (!flush_i[i] || (stage_clr_o[i] && !stage_en_o[i]));
      assert_excl_R6: assert (!(stage_en_o[i] && stage_clr_o[i]));
    end
  end

endmodule

bind pipe_handshake_ctrl pipe_handshake_chk #(
  .NUM_STAGES (NUM_STAGES)
) u_chk (
  .stage_valid_i (stage_valid_i),
  .local_ready_i (local_ready_i),
  .flush_i       (flush_i),
  .stage_en_o    (stage_en_o),
  .stage_clr_o   (stage_clr_o),
  .ready_o       (ready_o)
);

// File: tb/tb_pipe_handshake_ctrl.sv
module tb_pipe_handshake_ctrl;

  localparam int N = 4;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] valid, lrdy, flush;
  logic [N-1:0] en, clr, rdy;
  logic [N-1:0] e_en, e_clr, e_rdy;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pipe_handshake_ctrl #(.NUM_STAGES(N)) dut (
    .stage_valid_i (valid),
    .local_ready_i (lrdy),
    .flush_i       (flush),
    .stage_en_o    (en),
    .stage_clr_o   (clr),
    .ready_o       (rdy)
  );

  // Behavioural reference: walk from writeback toward fetch
  task automatic model(input logic [N-1:0] v, r, f,
                       output logic [N-1:0] oe, oc, orr);
    bit down;
    down = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      orr[i] = down && r[i];
      if (f[i])       begin oe[i] = 1'b0; oc[i] = 1'b1; end
      else if (!down) begin oe[i] = 1'b0; oc[i] = 1'b0; end
      else            begin oe[i] = v[i]; oc[i] = !v[i]; end
      down = orr[i];
    end
  endtask

  task automatic check(input string tag, input logic [N-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (v=%b r=%b f=%b)",
               tag, act, exp, valid, lrdy, flush);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, r, f);
    @(posedge clk);
    #1;
    valid = v; lrdy = r; flush = f;
    @(negedge clk);
    model(v, r, f, e_en, e_clr, e_rdy);
  endtask

  task automatic compare_all();
    check("R1 ready_o", rdy, e_rdy);
    check("R2 R5 stage_en_o", en, e_en);
    check("R3 R5 stage_clr_o", clr, e_clr);
    check("R6 en/clr overlap", en & clr, '0);
  endtask

  initial begin
    valid = '0; lrdy = '0; flush = '0;

    // Idle pipeline: only writeback sees ready, and clears as it is empty
    apply('0, '0, '0);
    check("R3 idle clear", clr, 4'b1000);
    check("R1 idle ready", rdy, 4'b0000);

    // R4: execute stage stalls, upstream holds
    apply(4'b1111, 4'b1011, 4'b0000);
    check("R4 hold en", en, 4'b1100);
    check("R4 hold clr", clr, 4'b0000);
    check("R1 stalled ready", rdy, 4'b1000);

    // R5: flush coincides with advance on stages 0 and 2
    apply(4'b1111, 4'b1111, 4'b0101);
    check("R5 flush vs enable en", en, 4'b1010);
    check("R5 flush vs enable clr", clr, 4'b0101);
    check("R5 ready unaffected", rdy, 4'b1111);

    // R8: writeback not locally ready still enables, blocks upstream
    apply(4'b1000, 4'b0111, 4'b0000);
    check("R8 writeback en", en, 4'b1000);
    check("R8 ready blocked", rdy, 4'b0000);

    // Exhaustive sweep of every input pattern against the reference
    for (int k = 0; k < (1 << (3 * N)); k++) begin
      apply(k[N-1:0], k[2*N-1:N], k[3*N-1:2*N]);
      compare_all();
    end

    // R7: downstream stages 2..3 fixed, upstream stages 0..1 swept
    begin
      logic [N-1:0] base_en, base_clr, base_rdy;
      apply(4'b1000, 4'b1100, 4'b0100);
      base_en = en; base_clr = clr; base_rdy = rdy;
      for (int k = 0; k < 64; k++) begin
        apply({2'b10, k[1:0]}, {2'b11, k[3:2]}, {2'b01, k[5:4]});
        check("R7 downstream en", en[3:2], base_en[3:2]);
        check("R7 downstream clr", clr[3:2], base_clr[3:2]);
        check("R7 downstream ready", rdy[3:2], base_rdy[3:2]);
        compare_all();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule